// File: doc/BRIEF.md
# Byte-Memory I2C Target

This block is an I2C target that gives an external bus controller access to a small on-chip byte memory. SCL and SDA pass through a synchronizer and are sampled on the system clock. The block never drives SDA high. It only pulls SDA low through an open-drain enable. It does not stretch the clock, does not answer the general call, and accepts 7-bit addresses only.

A write transaction carries an offset byte first. That byte loads an internal pointer, and each later data byte is stored at the pointer, which then advances. A read transaction returns bytes starting at the pointer, and the pointer advances after every byte sent. The pointer wraps inside the memory, and it keeps its value from one transaction to the next, so a read can follow an offset-only write.

When a transfer ends, at STOP or at a repeated START, the block raises a one-cycle end-of-write or end-of-read pulse. Together with the pulse it presents the offset at which that transfer began. These pins are plain control outputs. They carry no handshake and cannot be back-pressured, so a consumer has to capture the offset in the same cycle as the pulse.

Top module: `i2c_regmem_target`

## Requirements
- R1: The target acknowledges only the 7-bit address TGT_ADDR (default 0x43; the byte after START is address in bits 7:1 and read flag in bit 0, 1 = read). For any other address it leaves SDA released in the acknowledge slot and for the rest of the transaction, until the next START.
- R2: In a write, the first byte after the address sets the pointer to its low log2(MEM_DEPTH) bits (3 bits for 8 bytes). Every later byte is stored at the pointer, the pointer then advances by one, and each byte is acknowledged by pulling SDA low in the ninth clock.
- R3: The write pointer wraps modulo MEM_DEPTH. A write longer than the memory keeps wrapping, so later bytes overwrite earlier ones.
- R4: In a read, bytes are sent MSB first, starting at the pointer. The pointer advances after each byte and wraps modulo MEM_DEPTH.
- R5: The pointer persists across transactions. A read after an offset-only write starts at that offset, and a read after another read continues where the earlier one stopped.
- R6: When a write transfer ends at STOP or repeated START, wr_end_pulse is high for one cycle and end_offset holds the offset byte of that write, or 0 if no offset byte arrived (an address-only probe). Non-acknowledged transactions produce no pulse.
- R7: When a read transfer ends, rd_end_pulse is high for one cycle and end_offset holds the pointer value at which the read began. The two pulses never coincide.
- R8: When the controller answers a read byte with NACK (SDA high in the ninth clock), the target stops sending and keeps SDA released until STOP or START.
- R9: After reset the memory holds zeros, the pointer is 0, SDA is released and no end pulse is active.
- R10: START is SDA falling while SCL is high, and STOP is SDA rising while SCL is high. A repeated START ends the current transfer, discards any partial byte and returns to the address phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, which oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | SCL line level (asynchronous) |
| sda_in | input | 1 | SDA line level (asynchronous) |
| sda_pull_low | output | 1 | Open-drain enable: 1 pulls SDA low, 0 releases it |
| wr_end_pulse | output | 1 | One-cycle pulse when a write transfer ends |
| rd_end_pulse | output | 1 | One-cycle pulse when a read transfer ends |
| end_offset | output | PW | Start offset of the transfer that just ended; valid with a pulse |

## Verification
The bench first fills the memory with a short in-range write, then with a write that crosses the top address, then with one longer than the whole memory. These three cases separate plain increment from modulo wrap and from overwrite on the second lap. Reads are tried after an offset-only write with a STOP, after a repeated START, and directly after another read. These cases show whether the pointer survives between transactions and whether a read that stops on NACK leaves the pointer in the right place. Three further cases cover what is refused or cut short: a foreign address, an address-only probe and a repeated START in the middle of a byte. Together they show that NACKed traffic changes nothing, that a probe reports offset 0 and that a partial byte is never stored.

// File: rtl/i2c_regmem_pkg.sv
package i2c_regmem_pkg;

  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ACK_ADDR,
    ST_WR,
    ST_ACK_WR,
    ST_RD,
    ST_RD_ACK,
    ST_IGNORE
  } bus_state_e;

  typedef enum logic [1:0] {
    XFER_NONE,
    XFER_WR,
    XFER_RD
  } xfer_e;

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  output logic scl_lvl,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);

  logic [STAGES-1:0] scl_pipe;
  logic [STAGES-1:0] sda_pipe;
  logic              scl_prev;
  logic              sda_prev;

  // The bus idles high, so every stage resets to 1.
  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          scl_pipe <= '1;
          sda_pipe <= '1;
        end else begin
          scl_pipe <= scl_in;
          sda_pipe <= sda_in;
        end
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          scl_pipe <= '1;
          sda_pipe <= '1;
        end else begin
          scl_pipe <= {scl_pipe[STAGES-2:0], scl_in};
          sda_pipe <= {sda_pipe[STAGES-2:0], sda_in};
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_prev <= 1'b1;
      sda_prev <= 1'b1;
    end else begin
      scl_prev <= scl_lvl;
      sda_prev <= sda_lvl;
    end
  end

  assign scl_lvl   = scl_pipe[STAGES-1];
  assign sda_lvl   = sda_pipe[STAGES-1];
  assign scl_rise  = scl_lvl & ~scl_prev;
  assign scl_fall  = ~scl_lvl & scl_prev;
  assign start_det = scl_lvl & scl_prev & sda_prev & ~sda_lvl;
  assign stop_det  = scl_lvl & scl_prev & ~sda_prev & sda_lvl;

endmodule

// File: rtl/i2c_regmem_store.sv
module i2c_regmem_store #(
  parameter int DEPTH = 8,
  parameter int W     = 8,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);

  logic [W-1:0] cells [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) cells[i] <= '0;
    end else if (we) begin
      for (int i = 0; i < DEPTH; i++)
        if (waddr == AW'(i)) cells[i] <= wdata;
    end
  end

  assign rdata = cells[raddr];

  // R2: a committed byte is readable at its location on the next cycle
  a_r2_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (cells[$past(waddr)] == $past(wdata)));

endmodule

// File: rtl/i2c_regmem_target.sv
module i2c_regmem_target
  import i2c_regmem_pkg::*;
#(
  parameter logic [6:0] TGT_ADDR    = 7'h43,
  parameter int         MEM_DEPTH   = 8,
  parameter int         SYNC_STAGES = 2,
  parameter int         PW          = $clog2(MEM_DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_in,
  input  logic          sda_in,
  output logic          sda_pull_low,
  output logic          wr_end_pulse,
  output logic          rd_end_pulse,
  output logic [PW-1:0] end_offset
);

  localparam logic [2:0] LAST_BIT = 3'd7;

  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;

  bus_state_e        state;
  xfer_e             xfer;
  logic [2:0]        bit_cnt;
  logic [BYTE_W-1:0] rx_sh;
  logic [BYTE_W-1:0] tx_sh;
  logic [BYTE_W-1:0] rx_byte;
  logic              byte_full;
  logic              addr_hit;
  logic              rw_bit;
  logic              first_byte;
  logic              ctrl_ack;
  logic [PW-1:0]     ptr;
  logic [PW-1:0]     wr_off;
  logic [PW-1:0]     rd_off;
  logic              mem_we;
  logic [BYTE_W-1:0] mem_rdata;

  i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_in   (scl_in),
    .sda_in   (sda_in),
    .scl_lvl  (scl_s),
    .sda_lvl  (sda_s),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_det(start_det),
    .stop_det (stop_det)
  );

  assign rx_byte = {rx_sh[BYTE_W-2:0], sda_s};

  // A data byte (not the offset) is committed on the rising edge of its eighth bit.
  assign mem_we = (state == ST_WR) && scl_rise && (bit_cnt == LAST_BIT) &&
                  !first_byte && !start_det && !stop_det;

  i2c_regmem_store #(.DEPTH(MEM_DEPTH), .W(BYTE_W), .AW(PW)) u_store (
    .clk  (clk),
    .rst_n(rst_n),
    .we   (mem_we),
    .waddr(ptr),
    .wdata(rx_byte),
    .raddr(ptr),
    .rdata(mem_rdata)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state        <= ST_IDLE;
      xfer         <= XFER_NONE;
      bit_cnt      <= '0;
      rx_sh        <= '0;
      tx_sh        <= '0;
      byte_full    <= 1'b0;
      addr_hit     <= 1'b0;
      rw_bit       <= 1'b0;
      first_byte   <= 1'b0;
      ctrl_ack     <= 1'b0;
      ptr          <= '0;
      wr_off       <= '0;
      rd_off       <= '0;
      sda_pull_low <= 1'b0;
      wr_end_pulse <= 1'b0;
      rd_end_pulse <= 1'b0;
      end_offset   <= '0;
    end else begin
      wr_end_pulse <= 1'b0;
      rd_end_pulse <= 1'b0;
      if (start_det || stop_det) begin
        // Bus condition closes whatever transfer was running.
        if (xfer == XFER_WR) begin
          wr_end_pulse <= 1'b1;
          end_offset   <= wr_off;
        end else if (xfer == XFER_RD) begin
          rd_end_pulse <= 1'b1;
          end_offset   <= rd_off;
        end
        xfer         <= XFER_NONE;
        state        <= start_det ? ST_ADDR : ST_IDLE;
        bit_cnt      <= '0;
        byte_full    <= 1'b0;
        sda_pull_low <= 1'b0;
      end else begin
        unique case (state)
          ST_IDLE, ST_IGNORE: sda_pull_low <= 1'b0;

          ST_ADDR: begin
            if (scl_rise) begin
              rx_sh   <= rx_byte;
              bit_cnt <= bit_cnt + 3'd1;
              if (bit_cnt == LAST_BIT) begin
                byte_full <= 1'b1;
                addr_hit  <= (rx_byte[7:1] == TGT_ADDR);
                rw_bit    <= rx_byte[0];
              end
            end else if (scl_fall && byte_full) begin
              byte_full <= 1'b0;
              if (addr_hit) begin
                state        <= ST_ACK_ADDR;
                sda_pull_low <= 1'b1;
              end else begin
                state <= ST_IGNORE;
              end
            end
          end

          ST_ACK_ADDR: begin
            if (scl_fall) begin
              bit_cnt <= '0;
              if (rw_bit) begin
                state        <= ST_RD;
                xfer         <= XFER_RD;
                rd_off       <= ptr;
                tx_sh        <= mem_rdata;
                sda_pull_low <= ~mem_rdata[BYTE_W-1];
              end else begin
                state        <= ST_WR;
                xfer         <= XFER_WR;
                wr_off       <= '0;
                first_byte   <= 1'b1;
                sda_pull_low <= 1'b0;
              end
            end
          end

          ST_WR: begin
            if (scl_rise) begin
              rx_sh   <= rx_byte;
              bit_cnt <= bit_cnt + 3'd1;
              if (bit_cnt == LAST_BIT) begin
                byte_full <= 1'b1;
                if (first_byte) begin
                  ptr        <= rx_byte[PW-1:0];
                  wr_off     <= rx_byte[PW-1:0];
                  first_byte <= 1'b0;
                end else begin
                  ptr <= ptr + PW'(1);
                end
              end
            end else if (scl_fall && byte_full) begin
              byte_full    <= 1'b0;
              state        <= ST_ACK_WR;
              sda_pull_low <= 1'b1;
            end
          end

          ST_ACK_WR: begin
            if (scl_fall) begin
              state        <= ST_WR;
              sda_pull_low <= 1'b0;
            end
          end

          ST_RD: begin
            if (scl_fall) begin
              if (bit_cnt == LAST_BIT) begin
                sda_pull_low <= 1'b0;
                state        <= ST_RD_ACK;
                ptr          <= ptr + PW'(1);
              end else begin
                bit_cnt      <= bit_cnt + 3'd1;
                tx_sh        <= {tx_sh[BYTE_W-2:0], 1'b0};
                sda_pull_low <= ~tx_sh[BYTE_W-2];
              end
            end
          end

          ST_RD_ACK: begin
            if (scl_rise) begin
              ctrl_ack <= ~sda_s;
            end else if (scl_fall) begin
              if (ctrl_ack) begin
                state        <= ST_RD;
                bit_cnt      <= '0;
                tx_sh        <= mem_rdata;
                sda_pull_low <= ~mem_rdata[BYTE_W-1];
              end else begin
                state <= ST_IGNORE;
              end
            end
          end

          default: state <= ST_IDLE;
        endcase
      end
    end
  end

  // R1: the address acknowledge holds SDA low throughout SCL high
  a_r1_ack_held: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_ACK_ADDR && scl_s) |-> sda_pull_low);

  // R8: once ignoring, the target never pulls SDA
  a_r8_ignore_released: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IGNORE) |-> !sda_pull_low);

  // R7: write and read end pulses never coincide
  a_r7_one_event: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_end_pulse && rd_end_pulse));

  // R10: STOP returns to idle, START enters the address phase
  a_r10_stop_idle: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> (state == ST_IDLE));

  a_r10_start_addr: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> (state == ST_ADDR));

  // R6: an end pulse is only raised after a bus condition
  a_r6_pulse_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_end_pulse) |-> $past(start_det || stop_det));

endmodule

// File: tb/test_i2c_regmem_target.sv
module test_i2c_regmem_target;

  localparam int Q = 8;
  localparam logic [6:0] ADDR = 7'h43;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_c = 1'b1;
  logic sda_c = 1'b1;
  logic sda_line;
  logic sda_pull_low, wr_end_pulse, rd_end_pulse;
  logic [2:0] end_offset;

  always #5 clk = ~clk;

  assign sda_line = sda_c & ~sda_pull_low;

  i2c_regmem_target i_i2c_regmem_target (
    .clk         (clk),
    .rst_n       (rst_n),
    .scl_in      (scl_c),
    .sda_in      (sda_line),
    .sda_pull_low(sda_pull_low),
    .wr_end_pulse(wr_end_pulse),
    .rd_end_pulse(rd_end_pulse),
    .end_offset  (end_offset)
  );

  typedef struct {
    bit         is_rd;
    logic [2:0] off;
  } evt_t;

  evt_t       exp_q[$];
  evt_t       got;
  int         n_chk = 0;
  int         n_fail = 0;
  logic [7:0] mmem[8];
  logic [2:0] mptr = '0;
  logic [7:0] pay[16];
  bit         done = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_c = 1'b1; tick(Q);
    scl_c = 1'b1; tick(Q);
    sda_c = 1'b0; tick(Q);
    scl_c = 1'b0; tick(Q);
  endtask

  task automatic bus_stop();
    sda_c = 1'b0; tick(Q);
    scl_c = 1'b1; tick(Q);
    sda_c = 1'b1; tick(2 * Q);
  endtask

  task automatic put_bit(input bit b);
    sda_c = b; tick(Q);
    scl_c = 1'b1; tick(2 * Q);
    scl_c = 1'b0; tick(Q);
  endtask

  task automatic get_bit(output bit b);
    sda_c = 1'b1; tick(Q);
    scl_c = 1'b1; tick(Q);
    b = sda_line; tick(Q);
    scl_c = 1'b0; tick(Q);
  endtask

  task automatic send(input logic [7:0] v, output bit ack);
    bit r;
    for (int i = 7; i >= 0; i--) put_bit(v[i]);
    get_bit(r);
    ack = !r;
  endtask

  task automatic recv(output logic [7:0] v, input bit ack);
    bit r;
    for (int i = 7; i >= 0; i--) begin
      get_bit(r);
      v[i] = r;
    end
    put_bit(!ack);
  endtask

  task automatic push(input bit is_rd, input logic [2:0] off);
    evt_t e;
    e.is_rd = is_rd;
    e.off   = off;
    exp_q.push_back(e);
  endtask

  task automatic addr_phase(input bit rd, input string req);
    bit a;
    send({ADDR, rd}, a);
    chk(a, req, "address ACK", a, 1);
  endtask

  // Write: offset byte then n payload bytes, closed by STOP.
  task automatic wr_txn(input logic [7:0] off, input int n, input string req);
    bit a;
    bus_start();
    addr_phase(1'b0, req);
    send(off, a);
    chk(a, req, "offset ACK", a, 1);
    mptr = off[2:0];
    for (int i = 0; i < n; i++) begin
      send(pay[i], a);
      chk(a, req, "data ACK", a, 1);
      mmem[mptr] = pay[i];
      mptr = mptr + 3'd1;
    end
    push(1'b0, off[2:0]);
    bus_stop();
  endtask

  task automatic rd_body(input int n, input bit extra, input string req);
    logic [7:0] v;
    bit r;
    for (int i = 0; i < n; i++) begin
      recv(v, i != n - 1);
      chk(v === mmem[mptr], req, "read byte", v, mmem[mptr]);
      mptr = mptr + 3'd1;
    end
    if (extra) begin
      for (int i = 0; i < 8; i++) begin
        get_bit(r);
        chk(r == 1'b1, "R8", "SDA after NACK", r, 1);
      end
    end
  endtask

  task automatic rd_txn(input int n, input bit extra, input string req);
    logic [2:0] st;
    bus_start();
    addr_phase(1'b1, req);
    st = mptr;
    rd_body(n, extra, req);
    push(1'b1, st);
    bus_stop();
  endtask

  // Scoreboard monitor: compares each end pulse with the queued expectation.
  always @(negedge clk) begin
    if (rst_n && (wr_end_pulse || rd_end_pulse)) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R6", "unexpected end pulse", {wr_end_pulse, rd_end_pulse}, 0);
      end else begin
        got = exp_q.pop_front();
        chk(rd_end_pulse == got.is_rd && wr_end_pulse == !got.is_rd,
            got.is_rd ? "R7" : "R6", "event kind", rd_end_pulse, got.is_rd);
        chk(end_offset == got.off, got.is_rd ? "R7" : "R6", "event offset",
            end_offset, got.off);
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    bit a;
    for (int i = 0; i < 8; i++) mmem[i] = 8'h00;
    tick(5);
    // R9: reset state
    chk(sda_pull_low == 1'b0, "R9", "SDA released in reset", sda_pull_low, 0);
    chk(!wr_end_pulse && !rd_end_pulse, "R9", "no pulse in reset",
        {wr_end_pulse, rd_end_pulse}, 0);
    rst_n = 1'b1;
    tick(5);

    // R9/R10: offset write, repeated START, read of zeroed memory
    bus_start();
    addr_phase(1'b0, "R10");
    send(8'h00, a);
    chk(a, "R10", "offset ACK", a, 1);
    mptr = 3'd0;
    push(1'b0, 3'd0);
    bus_start();
    addr_phase(1'b1, "R10");
    rd_body(8, 1'b0, "R9");
    push(1'b1, 3'd0);
    bus_stop();

    // R2: plain write then full read
    for (int i = 0; i < 8; i++) pay[i] = 8'h30 + 8'(i);
    wr_txn(8'h00, 8, "R2");
    rd_txn(8, 1'b0, "R2");

    // R3: write crossing the top
    pay[0] = "t"; pay[1] = "e"; pay[2] = "s"; pay[3] = "t";
    wr_txn(8'h06, 4, "R3");
    wr_txn(8'h00, 0, "R5");
    rd_txn(8, 1'b0, "R3");

    // R3/R4: write and read longer than the memory
    for (int i = 0; i < 12; i++) pay[i] = 8'hA0 + 8'(i);
    wr_txn(8'h00, 12, "R3");
    wr_txn(8'h00, 0, "R5");
    rd_txn(12, 1'b0, "R4");

    // R5/R2: offset byte 0x0A uses its low bits (2); reads continue; R8 after NACK
    wr_txn(8'h0A, 0, "R5");
    rd_txn(4, 1'b0, "R5");
    rd_txn(4, 1'b1, "R5");

    // R6: address-only probe reports offset 0
    bus_start();
    addr_phase(1'b0, "R6");
    push(1'b0, 3'd0);
    bus_stop();

    // R1: foreign address is refused and ignored
    bus_start();
    send({7'h42, 1'b0}, a);
    chk(!a, "R1", "foreign address NACK", a, 0);
    send(8'h05, a);
    chk(!a, "R1", "ignored byte NACK", a, 0);
    send(8'h99, a);
    bus_stop();
    bus_start();
    send({7'h42, 1'b1}, a);
    chk(!a, "R1", "foreign read NACK", a, 0);
    recv(v, 1'b0);
    chk(v == 8'hFF, "R1", "foreign read released", v, 8'hFF);
    bus_stop();
    rd_txn(8, 1'b0, "R1");

    // R10: repeated START in the middle of a byte discards it
    bus_start();
    addr_phase(1'b0, "R10");
    send(8'h05, a);
    mptr = 3'd5;
    send(8'h5A, a);
    chk(a, "R10", "data ACK", a, 1);
    mmem[5] = 8'h5A;
    mptr = 3'd6;
    put_bit(1'b1); put_bit(1'b0); put_bit(1'b1);
    push(1'b0, 3'd5);
    bus_start();
    addr_phase(1'b1, "R10");
    push(1'b1, 3'd6);
    rd_body(2, 1'b0, "R10");
    bus_stop();
    wr_txn(8'h05, 0, "R10");
    rd_txn(1, 1'b0, "R10");

    tick(50);
    chk(exp_q.size() == 0, "R6", "missing end pulses", exp_q.size(), 0);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule